// File: doc/BRIEF.md
# Two-Way Cache Way Predictor

This block guesses, for each access to a two-way set-associative cache, which of the two ways will hold the block. The guess is ready before the tag compare, so the cache can read its data array and tag array in the same cycle. The guess comes from a table of single-bit entries, one bit per entry, with 2^IDX_W entries. The table is addressed by the lowest IDX_W bits of the block address. These are the bits just above the byte offset. The offset bits never take part.

An access has two steps. In the lookup cycle the address is presented and the prediction appears combinationally. The predicted way and the table index are then held in a one-deep pending register. In a later cycle the cache presents its real outcome: either a hit and the way that hit, or a miss and the way the new block was filled into. The block then sorts the access into exactly one class: correct hit, mispredicted hit or miss. It retrains the table only on a miss fill or on a mispredicted hit, and it counts each class in its own 32-bit counter. A miss is never counted as a misprediction. A new lookup may be presented in the same cycle as the outcome of the previous one.

Top module: `way_predictor`

## Requirements
- R1: While rst_n is low at a clock edge, every table entry returns to way 0 and all three counters return to zero. After reset, acc_class is 0 whenever no outcome is being consumed.
- R2: The pred_way output is a combinational function of the entry selected by lkp_addr[OFF_W+IDX_W-1:OFF_W]. It does not depend on the offset bits lkp_addr[OFF_W-1:0] or on any address bit above the index field.
- R3: An outcome with res_hit=0 is classed as miss (acc_class=3). The entry of the pending lookup is written with res_way.
- R4: An outcome with res_hit=1 and res_way different from the pending prediction is classed as mispredicted hit (acc_class=2). That entry is rewritten with res_way.
- R5: An outcome with res_hit=1 and res_way equal to the pending prediction is classed as correct hit (acc_class=1). The table is left unchanged.
- R6: Each consumed outcome adds exactly one, on the following clock edge, to the counter of its class: cnt_hit for class 1, cnt_misp for class 2, cnt_miss for class 3. The other two counters are unchanged.
- R7: An outcome presented with no pending lookup is ignored. acc_class stays 0, and no counter or table entry changes.
- R8: A table write takes effect at the clock edge that ends the outcome cycle. A lookup to the same entry in that same cycle returns the value held before the write.
- R9: With IDX_W=0 the table has a single entry, shared by every address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | A lookup is presented this cycle |
| lkp_addr | input | ADDR_W | Byte address of the lookup |
| pred_way | output | 1 | Predicted way for lkp_addr |
| res_valid | input | 1 | The cache outcome for the pending lookup is presented |
| res_hit | input | 1 | 1 = hit, 0 = miss |
| res_way | input | 1 | Way that hit, or way filled on a miss |
| acc_class | output | 2 | 0 none, 1 correct hit, 2 mispredicted hit, 3 miss |
| cnt_hit | output | CNT_W | Correct-hit count |
| cnt_misp | output | CNT_W | Mispredicted-hit count |
| cnt_miss | output | CNT_W | Miss count |

## Verification
Random addresses with random offsets and upper bits drive an eight-entry instance and a single-entry instance in parallel. Aliasing and offset independence therefore show up in the predictions of both. Outcomes are biased toward the predicted way, with a share of misses and wrong-way hits. This separates the three training cases: a design that trains on correct hits, skips training on misses, or counts misses as mispredictions diverges from the bench model. Directed cases cover the reset state, an outcome that overlaps a lookup to the same entry (old value returned), and an outcome with no pending lookup.

// File: rtl/wp_pkg.sv
// Shared types for the way predictor: access classification codes.
package wp_pkg;
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_HIT  = 2'd1,
        CLS_MISP = 2'd2,
        CLS_MISS = 2'd3
    } acc_class_t;
endpackage

// File: rtl/wp_index.sv
// Index extraction: picks the IDX_W bits just above the byte offset.
// Assumes OFF_W + IDX_W <= ADDR_W. With IDX_W = 0 the index is constant 0.
module wp_index #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 10,
    parameter int SEL_W  = (IDX_W == 0) ? 1 : IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SEL_W-1:0]  idx
);
    generate
        if (IDX_W == 0) begin : g_single
            // single entry: every address selects entry 0
            assign idx = '0;
        end else begin : g_field
            // index field sits directly above the byte offset
            assign idx = addr[OFF_W +: IDX_W];
        end
    endgenerate
endmodule

// File: rtl/wp_table.sv
// Prediction table: ENTRIES one-bit entries with a combinational read port
// and one synchronous write port. Reset clears every entry to way 0.
module wp_table #(
    parameter int IDX_W   = 10,
    parameter int SEL_W   = (IDX_W == 0) ? 1 : IDX_W,
    parameter int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rd_idx,
    output logic             rd_way,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic             wr_way
);
    logic [ENTRIES-1:0] bits_q;

    // combinational read of the stored bit (old value during a write cycle)
    assign rd_way = bits_q[rd_idx];

    // training write and reset to way 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q[wr_idx] <= wr_way;
        end
    end

    // R3
    tbl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bits_q[$past(wr_idx)] == $past(wr_way)));
endmodule

// File: rtl/wp_classify.sv
// Pending lookup register and outcome classifier. Holds the index and
// predicted way of the latest lookup, then classifies the cache outcome
// and issues the training write. Assumes one outcome per lookup, in order.
module wp_classify
    import wp_pkg::*;
#(
    parameter int SEL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_valid,
    input  logic [SEL_W-1:0] lkp_idx,
    input  logic             lkp_pred,
    input  logic             res_valid,
    input  logic             res_hit,
    input  logic             res_way,
    output acc_class_t       acc_class,
    output logic             wr_en,
    output logic [SEL_W-1:0] wr_idx,
    output logic             wr_way
);
    logic             pend_valid;
    logic [SEL_W-1:0] pend_idx;
    logic             pend_pred;
    logic             consume;

    assign consume = res_valid && pend_valid;

    // capture a new lookup; drop the pending one once its outcome arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_idx   <= '0;
            pend_pred  <= 1'b0;
        end else if (lkp_valid) begin
            pend_valid <= 1'b1;
            pend_idx   <= lkp_idx;
            pend_pred  <= lkp_pred;
        end else if (consume) begin
            pend_valid <= 1'b0;
        end
    end

    // classify the outcome against the held prediction
    always_comb begin
        if (!consume)                 acc_class = CLS_NONE;
        else if (!res_hit)            acc_class = CLS_MISS;
        else if (res_way == pend_pred) acc_class = CLS_HIT;
        else                          acc_class = CLS_MISP;
    end

    // train on fills and on wrong-way hits only
    always_comb begin
        wr_en  = (acc_class == CLS_MISS) || (acc_class == CLS_MISP);
        wr_idx = pend_idx;
        wr_way = res_way;
    end

    // R4
    misp_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == CLS_MISP) |-> res_hit);

    // R7
    pend_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !lkp_valid) |=> (acc_class == CLS_NONE));
endmodule

// File: rtl/wp_counters.sv
// Event counters, one per access class. Each wraps at 2^CNT_W.
module wp_counters
    import wp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_class_t       acc_class,
    output logic [CNT_W-1:0] cnt_hit,
    output logic [CNT_W-1:0] cnt_misp,
    output logic [CNT_W-1:0] cnt_miss
);
    localparam int SUM_W = CNT_W + 2;
    logic [SUM_W-1:0] total;

    // bump the counter of the class seen this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_hit  <= '0;
            cnt_misp <= '0;
            cnt_miss <= '0;
        end else begin
            case (acc_class)
                CLS_HIT:  cnt_hit  <= cnt_hit + 1'b1;
                CLS_MISP: cnt_misp <= cnt_misp + 1'b1;
                CLS_MISS: cnt_miss <= cnt_miss + 1'b1;
                default:  ;
            endcase
        end
    end

    assign total = SUM_W'(cnt_hit) + SUM_W'(cnt_misp) + SUM_W'(cnt_miss);

    // R6
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class != CLS_NONE) |=> (total == $past(total) + 1'b1));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == CLS_NONE) |=> $stable(total));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (total == '0));
endmodule

// File: rtl/way_predictor.sv
// Top of the way predictor for a two-way set-associative cache.
// Predicts combinationally from lkp_addr, holds one pending lookup,
// classifies the cache outcome, trains the table and counts classes.
module way_predictor
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int IDX_W  = 10,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              pred_way,
    input  logic              res_valid,
    input  logic              res_hit,
    input  logic              res_way,
    output logic [1:0]        acc_class,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_misp,
    output logic [CNT_W-1:0]  cnt_miss
);
    localparam int SEL_W   = (IDX_W == 0) ? 1 : IDX_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [SEL_W-1:0] lkp_idx;
    logic             wr_en;
    logic [SEL_W-1:0] wr_idx;
    logic             wr_way;
    acc_class_t       cls;

    wp_index #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_index (
        .addr(lkp_addr),
        .idx (lkp_idx)
    );

    wp_table #(
        .IDX_W(IDX_W), .SEL_W(SEL_W), .ENTRIES(ENTRIES)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(lkp_idx),
        .rd_way(pred_way),
        .wr_en (wr_en),
        .wr_idx(wr_idx),
        .wr_way(wr_way)
    );

    wp_classify #(.SEL_W(SEL_W)) u_classify (
        .clk      (clk),
        .rst_n    (rst_n),
        .lkp_valid(lkp_valid),
        .lkp_idx  (lkp_idx),
        .lkp_pred (pred_way),
        .res_valid(res_valid),
        .res_hit  (res_hit),
        .res_way  (res_way),
        .acc_class(cls),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_way   (wr_way)
    );

    wp_counters #(.CNT_W(CNT_W)) u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_class(cls),
        .cnt_hit  (cnt_hit),
        .cnt_misp (cnt_misp),
        .cnt_miss (cnt_miss)
    );

    assign acc_class = cls;

    // R3
    miss_not_misp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (acc_class != 2'd2) && (acc_class != 2'd1));
endmodule

// File: tb/way_predictor_tb.sv
`timescale 1ns/1ps
module way_predictor_tb;
    localparam int OFF = 6;
    localparam int N   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [31:0] lkp_addr = '0;
    logic        res_valid = 1'b0;
    logic        res_hit = 1'b0;
    logic        res_way = 1'b0;

    logic        pw8, pw1;
    logic [1:0]  cl8, cl1;
    logic [31:0] h8, m8, x8, h1, m1, x1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] mdl8;
    logic       mdl1;
    int eh8, em8, ex8, eh1, em1, ex1;

    always #4 clk = ~clk;

    way_predictor #(.ADDR_W(32), .OFF_W(OFF), .IDX_W(N), .CNT_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
        .pred_way(pw8), .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
        .acc_class(cl8), .cnt_hit(h8), .cnt_misp(m8), .cnt_miss(x8));

    way_predictor #(.ADDR_W(32), .OFF_W(OFF), .IDX_W(0), .CNT_W(32)) u_one (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
        .pred_way(pw1), .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
        .acc_class(cl1), .cnt_hit(h1), .cnt_misp(m1), .cnt_miss(x1));

    function automatic int idx_of(input logic [31:0] a);
        return int'((a >> OFF) & 32'h7);
    endfunction

    function automatic logic [1:0] exp_class(input logic pred, input logic hit, input logic way);
        if (!hit) return 2'd3;
        if (way == pred) return 2'd1;
        return 2'd2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bump(input logic [1:0] c, inout int eh, inout int em, inout int ex);
        if (c == 2'd1) eh++;
        else if (c == 2'd2) em++;
        else if (c == 2'd3) ex++;
    endtask

    task automatic check_counts();
        chk(h8 == eh8, "R6 hit count", h8, eh8);
        chk(m8 == em8, "R6 misp count", m8, em8);
        chk(x8 == ex8, "R6 miss count", x8, ex8);
        chk(h1 == eh1, "R9 hit count", h1, eh1);
        chk(m1 == em1, "R9 misp count", m1, em1);
        chk(x1 == ex1, "R9 miss count", x1, ex1);
    endtask

    // apply an outcome for the pending lookup and check/update the models
    task automatic outcome(input logic [31:0] a, input logic p8, input logic p1,
                           input logic hit, input logic way, input bit next_lkp,
                           input logic [31:0] na);
        logic [1:0] c8, c1;
        @(negedge clk);
        lkp_valid = next_lkp; lkp_addr = na;
        res_valid = 1'b1; res_hit = hit; res_way = way;
        #1;
        c8 = exp_class(p8, hit, way);
        c1 = exp_class(p1, hit, way);
        chk(cl8 == c8, "R3/R4/R5 class", cl8, c8);
        chk(cl1 == c1, "R9 class", cl1, c1);
        if (next_lkp) begin
            // R8: same-cycle lookup sees pre-write value
            chk(pw8 == mdl8[idx_of(na)], "R8 old value", pw8, mdl8[idx_of(na)]);
            chk(pw1 == mdl1, "R8 single old value", pw1, mdl1);
        end
        if (c8 != 2'd1) mdl8[idx_of(a)] = way;
        if (c1 != 2'd1) mdl1 = way;
        bump(c8, eh8, em8, ex8);
        bump(c1, eh1, em1, ex1);
    endtask

    task automatic lookup(input logic [31:0] a, output logic p8, output logic p1);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_addr = a; res_valid = 1'b0;
        #1;
        chk(pw8 == mdl8[idx_of(a)], "R2 prediction", pw8, mdl8[idx_of(a)]);
        chk(pw1 == mdl1, "R9 prediction", pw1, mdl1);
        p8 = pw8; p1 = pw1;
    endtask

    task automatic idle_check();
        @(negedge clk);
        lkp_valid = 1'b0; res_valid = 1'b0;
        #1;
        check_counts();
    endtask

    task automatic access(input logic [31:0] a, input logic hit, input logic way);
        logic p8, p1;
        lookup(a, p8, p1);
        outcome(a, p8, p1, hit, way, 1'b0, 32'h0);
        idle_check();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic p8, p1, q8, q1;
        void'($urandom(32'd501));
        mdl8 = '0; mdl1 = 1'b0;
        eh8 = 0; em8 = 0; ex8 = 0; eh1 = 0; em1 = 0; ex1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(cl8 == 2'd0, "R1 class idle", cl8, 0);
        check_counts();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); lkp_addr = 32'(i) << OFF; #1;
            chk(pw8 == 1'b0, "R1 entry way0", pw8, 0);
        end
        lkp_valid = 1'b0;
        idle_check();

        // R3: miss fill into way 1 at entry 5, then R2 offset/tag independence
        access(32'h0000_0140, 1'b0, 1'b1);
        lookup(32'hABCD_017F, p8, p1);
        chk(p8 == 1'b1, "R2 offset ignored", p8, 1);
        outcome(32'hABCD_017F, p8, p1, 1'b1, 1'b1, 1'b0, 32'h0);   // R5 correct hit
        idle_check();
        // R4 wrong-way hit retrains
        access(32'h0000_0140, 1'b1, 1'b0);
        lookup(32'h0000_0140, p8, p1);
        chk(p8 == 1'b0, "R4 retrained", p8, 0);
        outcome(32'h0000_0140, p8, p1, 1'b1, 1'b0, 1'b0, 32'h0);
        idle_check();

        // R7 stray outcome with nothing pending
        @(negedge clk);
        res_valid = 1'b1; res_hit = 1'b0; res_way = 1'b1; lkp_valid = 1'b0;
        #1;
        chk(cl8 == 2'd0, "R7 stray ignored", cl8, 0);
        idle_check();
        lookup(32'h0000_0140, p8, p1);
        chk(p8 == 1'b0, "R7 table untouched", p8, 0);
        outcome(32'h0000_0140, p8, p1, 1'b1, 1'b0, 1'b0, 32'h0);
        idle_check();

        // R8 overlapping outcome and lookup to the same entry
        lookup(32'h0000_00C0, p8, p1);
        outcome(32'h0000_00C0, p8, p1, 1'b0, 1'b1, 1'b1, 32'h1234_50C4);
        q8 = pw8; q1 = pw1;
        outcome(32'h1234_50C4, q8, q1, 1'b1, 1'b1, 1'b0, 32'h0);
        idle_check();

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic h, w;
            a = $urandom;
            h = ($urandom % 4) != 0;
            w = 1'(($urandom % 2));
            if (h && ($urandom % 3) != 0) w = mdl8[idx_of(a)];
            access(a, h, w);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule